// File: doc/BRIEF.md
# Serial Command Port and Modem Register Controller

This block is the host-facing slave of a narrowband modem. A host frames each transaction with an active-low chip select, clocks bytes in most-significant bit first on a serial clock, and begins every transaction with a one-byte command code. Depending on the code, the block then takes data bytes in or shifts one reply byte out. It keeps the modem's control byte, collects event flags raised by the modem datapath into a six-bit status word, and drives an active-low interrupt and a powersave indication.

Two copies can share one serial bus. A strap input selects which command map the copy answers, while the broadcast reset code reaches both. The serial clock, chip select and command data are sampled in the system clock domain through synchronisers, so the serial clock must be slow compared to `clk` (each serial clock phase at least four system clocks wide). Transmit bytes leave on a valid/ready pair: `tx_valid` stays high with `tx_data` stable until `tx_ready` is seen, and a newer write replaces a byte that has not yet been taken. The receive byte is taken combinationally from `rx_data`, and `rx_rd` tells the datapath that the byte was consumed.

Top module: `sbus_ctrl`

## Requirements
- R1: If chip select goes high before a byte's eighth serial-clock rise, the unfinished transaction is dropped and no register changes.
- R2: Bytes are taken MSB first on serial-clock rising edges. A command acts only after its last byte is complete. Code {0100,S,000} followed by one byte writes the control byte, where S is the strap value.
- R3: Control bits 7 and 6 are always stored as 0. Bit 0 is the mode (1 transmit), bit 1 is checksum enable, bit 2 is powersave request, bit 3 is interrupt enable, bit 4 is true-sync prime and bit 5 is inverted-sync prime.
- R4: With `addr_sel`=1, only codes 0x48 to 0x4C are accepted, and codes 0x40 to 0x44 are ignored along with the rest of the frame. With `addr_sel`=0 the reverse holds. Code 0x01 is accepted in both cases.
- R5: Code 0x01 clears the whole control byte. It leaves the status flags, the transmit byte and the sync word unchanged.
- R6: Code {0100,S,100} takes two bytes, high byte first. When the second byte completes, `sync_word` is updated and `sync_wr` pulses for one cycle.
- R7: Code {0100,S,001} returns {00, status} MSB first. Status bits are: 0 receive byte ready, 1 checksum good, 2 transmit byte wanted, 3 transmit idle, 4 true sync found, 5 inverted sync found. `reply_oe` is low whenever no reply byte is being shifted out.
- R8: A completed status read clears status bits 4 and 5 and releases the interrupt.
- R9: A one-cycle pulse on `status_set[i]` sets status bit i and marks an interrupt pending. `irq_n` is low only while an interrupt is pending and control bit 3 is 1.
- R10: A control write that changes bit 0 releases the interrupt. A change to transmit clears status bits 0, 1, 4 and 5. A change to receive clears bits 2 and 3.
- R11: Code {0100,S,011} plus one byte raises `tx_valid` with that byte and holds it until `tx_ready`. It also clears status bits 2 and 3.
- R12: Code {0100,S,010} returns `rx_data`. When the reply byte completes, `rx_rd` pulses once and status bits 0 and 1 are cleared.
- R13: `powersave` is 1 exactly when `wake` is 1 and control bit 2 is 1.
- R14: A pulse on `status_set[4]` clears control bit 4, and a pulse on `status_set[5]` clears control bit 5. This takes priority over a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low transaction frame |
| cmd_din | input | 1 | Serial command and data from host |
| addr_sel | input | 1 | Strap selecting the command map |
| wake | input | 1 | Permits powersave when 1 |
| reply_dout | output | 1 | Serial reply bit |
| reply_oe | output | 1 | Drive enable for reply_dout |
| irq_n | output | 1 | Active-low interrupt (drive low only) |
| powersave | output | 1 | Powersave indication |
| ctrl_word | output | 8 | Control byte to the modem datapath |
| status_set | input | 6 | Per-flag set pulses from the datapath |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Datapath accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_data | input | 8 | Current received byte |
| rx_rd | output | 1 | Received byte consumed |
| sync_wr | output | 1 | Sync word updated |
| sync_word | output | 16 | Programmed sync pattern |

## Verification
A wrong transaction phase shows up within one byte, as a write landing in the wrong register or as a reply with the wrong value or with `reply_oe` in the wrong state. A wrong bit count shifts every later byte in the same frame, so the next control readback is wrong. A flag that is set or cleared incorrectly is seen at the next status read. A lost or stale interrupt-pending state shows on `irq_n` a few system clocks after the datapath pulse, the status read or the mode change that should have moved it.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 6;
  localparam int SYNC_W = 16;
  localparam logic [7:0] RESET_CODE = 8'h01;
  localparam logic [3:0] CMD_PREFIX = 4'h4;

  localparam int ST_RXRDY  = 0;
  localparam int ST_CKOK   = 1;
  localparam int ST_TXRDY  = 2;
  localparam int ST_TXIDLE = 3;
  localparam int ST_SYNC   = 4;
  localparam int ST_NSYNC  = 5;

  localparam int CT_MODE   = 0;
  localparam int CT_IEN    = 3;
  localparam int CT_PRIME  = 4;
  localparam int CT_NPRIME = 5;
  localparam int CT_PSAVE  = 2;

  typedef enum logic [2:0] {
    PH_CMD, PH_CTRL, PH_TX, PH_SYNC_HI, PH_SYNC_LO, PH_REP_ST, PH_REP_RX, PH_SKIP
  } phase_e;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sbus_shift.sv
module sbus_shift
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              din_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              reply_bit,
  output logic              reply_oe
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic              sclk_d;
  logic              rise;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh_in;
  logic [BYTE_W-1:0] sh_out;

  assign rise = sclk_s & ~sclk_d & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; cnt <= '0; sh_in <= '0; sh_out <= '0;
      reply_oe <= 1'b0; byte_done <= 1'b0; byte_val <= '0;
    end else begin
      sclk_d    <= sclk_s;
      byte_done <= 1'b0;
      if (cs_s) begin
        cnt      <= '0;
        reply_oe <= 1'b0;
      end else begin
        if (rise) begin
          sh_in <= {sh_in[BYTE_W-2:0], din_s};
          cnt   <= cnt + CW'(1);
          if (cnt == LAST) begin
            byte_done <= 1'b1;
            byte_val  <= {sh_in[BYTE_W-2:0], din_s};
          end
          if (reply_oe) begin
            sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
            if (cnt == LAST) reply_oe <= 1'b0;
          end
        end
        if (load) begin
          sh_out   <= load_byte;
          reply_oe <= 1'b1;
        end
      end
    end
  end

  assign reply_bit = sh_out[BYTE_W-1];

  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !reply_oe);  // R7
  AST_BYTE_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);  // R2
endmodule

// File: rtl/sbus_regs.sv
module sbus_regs
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              addr_sel,
  input  logic [STAT_W-1:0] status_set,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_ready,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic [BYTE_W-1:0] ctrl,
  output logic              irq_pend,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              rx_rd,
  output logic              sync_wr,
  output logic [SYNC_W-1:0] sync_word
);
  localparam logic [STAT_W-1:0] CLR_SYNC = STAT_W'((1 << ST_SYNC) | (1 << ST_NSYNC));
  localparam logic [STAT_W-1:0] CLR_RX   = STAT_W'((1 << ST_RXRDY) | (1 << ST_CKOK));
  localparam logic [STAT_W-1:0] CLR_TX   = STAT_W'((1 << ST_TXRDY) | (1 << ST_TXIDLE));
  localparam int PAD = BYTE_W - STAT_W;

  phase_e            ph;
  logic [STAT_W-1:0] status;
  logic [BYTE_W-1:0] sync_hi;
  logic              hit, in_cmd, reset_hit, wr_ctrl, wr_tx, wr_sync;
  logic              rd_stat_done, rd_rx_done, mode_flip;
  logic [STAT_W-1:0] stat_clr, status_d;
  logic [BYTE_W-1:0] ctrl_d;

  assign in_cmd       = byte_done && (ph == PH_CMD);
  assign hit          = byte_val[7:3] == {CMD_PREFIX, addr_sel};
  assign reset_hit    = in_cmd && (byte_val == RESET_CODE);
  assign wr_ctrl      = byte_done && (ph == PH_CTRL);
  assign wr_tx        = byte_done && (ph == PH_TX);
  assign wr_sync      = byte_done && (ph == PH_SYNC_LO);
  assign rd_stat_done = byte_done && (ph == PH_REP_ST);
  assign rd_rx_done   = byte_done && (ph == PH_REP_RX);
  assign mode_flip    = wr_ctrl && (byte_val[CT_MODE] != ctrl[CT_MODE]);

  always_comb begin
    stat_clr = '0;
    if (rd_stat_done) stat_clr |= CLR_SYNC;
    if (rd_rx_done)   stat_clr |= CLR_RX;
    if (wr_tx)        stat_clr |= CLR_TX;
    if (mode_flip)    stat_clr |= byte_val[CT_MODE] ? (CLR_SYNC | CLR_RX) : CLR_TX;
    status_d = (status & ~stat_clr) | status_set;
    ctrl_d = ctrl;
    if (reset_hit) ctrl_d = '0;
    if (wr_ctrl)   ctrl_d = {{PAD{1'b0}}, byte_val[STAT_W-1:0]};
    if (status_set[ST_SYNC])  ctrl_d[CT_PRIME]  = 1'b0;
    if (status_set[ST_NSYNC]) ctrl_d[CT_NPRIME] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_CMD; status <= '0; ctrl <= '0; irq_pend <= 1'b0;
      load <= 1'b0; load_byte <= '0; sync_hi <= '0; sync_word <= '0;
      sync_wr <= 1'b0; rx_rd <= 1'b0; tx_valid <= 1'b0; tx_data <= '0;
    end else begin
      status   <= status_d;
      ctrl     <= ctrl_d;
      irq_pend <= (|status_set) | (irq_pend & ~(rd_stat_done | mode_flip));
      load     <= 1'b0;
      sync_wr  <= wr_sync;
      rx_rd    <= rd_rx_done;
      if (wr_sync) sync_word <= {sync_hi, byte_val};
      if (wr_tx) begin
        tx_valid <= 1'b1;
        tx_data  <= byte_val;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      if (cs_s) begin
        ph <= PH_CMD;
      end else if (byte_done) begin
        case (ph)
          PH_CMD: begin
            if (byte_val == RESET_CODE) ph <= PH_CMD;
            else if (!hit) ph <= PH_SKIP;
            else begin
              case (byte_val[2:0])
                3'd0: ph <= PH_CTRL;
                3'd1: begin ph <= PH_REP_ST; load <= 1'b1; load_byte <= {{PAD{1'b0}}, status}; end
                3'd2: begin ph <= PH_REP_RX; load <= 1'b1; load_byte <= rx_data; end
                3'd3: ph <= PH_TX;
                3'd4: ph <= PH_SYNC_HI;
                default: ph <= PH_SKIP;
              endcase
            end
          end
          PH_SYNC_HI: begin sync_hi <= byte_val; ph <= PH_SYNC_LO; end
          PH_SKIP:    ph <= PH_SKIP;
          default:    ph <= PH_CMD;
        endcase
      end
    end
  end

  AST_SYNC_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_wr |=> !sync_wr);  // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid);  // R11
  AST_STAT_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_done && (status_set == '0) |=> !irq_pend);  // R8
  AST_PRIME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    status_set[ST_SYNC] |=> !ctrl[CT_PRIME]);  // R14
  AST_RESET_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit && (status_set == '0) |=> status == $past(status));  // R5
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl[BYTE_W-1:STAT_W] == '0);  // R3
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              cmd_din,
  input  logic              addr_sel,
  input  logic              wake,
  output logic              reply_dout,
  output logic              reply_oe,
  output logic              irq_n,
  output logic              powersave,
  output logic [BYTE_W-1:0] ctrl_word,
  input  logic [STAT_W-1:0] status_set,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_rd,
  output logic              sync_wr,
  output logic [SYNC_W-1:0] sync_word
);
  logic [2:0]        s_vec;
  logic              byte_done, load, reply_bit, irq_pend;
  logic [BYTE_W-1:0] byte_val, load_byte;

  sbus_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, cmd_din}), .q(s_vec));

  sbus_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(s_vec[1]), .cs_s(s_vec[2]), .din_s(s_vec[0]),
    .load(load), .load_byte(load_byte), .byte_done(byte_done), .byte_val(byte_val),
    .reply_bit(reply_bit), .reply_oe(reply_oe));

  sbus_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cs_s(s_vec[2]), .byte_done(byte_done),
    .byte_val(byte_val), .addr_sel(addr_sel), .status_set(status_set),
    .rx_data(rx_data), .tx_ready(tx_ready), .load(load), .load_byte(load_byte),
    .ctrl(ctrl_word), .irq_pend(irq_pend), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_rd(rx_rd), .sync_wr(sync_wr), .sync_word(sync_word));

  assign reply_dout = reply_bit & reply_oe;
  assign irq_n      = ~(irq_pend & ctrl_word[CT_IEN]);
  assign powersave  = wake & ctrl_word[CT_PSAVE];
endmodule

// File: tb/sbus_ctrl_bench.sv
module sbus_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, cmd_din = 1'b0, addr_sel = 1'b0, wake = 1'b0;
  logic reply_dout, reply_oe, irq_n, powersave, tx_valid, rx_rd, sync_wr;
  logic [7:0] ctrl_word, tx_data;
  logic [7:0] rx_data = 8'h00;
  logic [5:0] status_set = 6'h00;
  logic tx_ready = 1'b0;
  logic [15:0] sync_word;

  int n_chk = 0, n_fail = 0, rx_rd_cnt = 0, sync_wr_cnt = 0;
  logic [7:0] m_ctrl = 8'h00;
  logic [5:0] m_stat = 6'h00;
  logic m_pend = 1'b0;

  always #2 clk = ~clk;

  sbus_ctrl u_sbus_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .cmd_din(cmd_din),
    .addr_sel(addr_sel), .wake(wake), .reply_dout(reply_dout), .reply_oe(reply_oe),
    .irq_n(irq_n), .powersave(powersave), .ctrl_word(ctrl_word), .status_set(status_set),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_data(rx_data),
    .rx_rd(rx_rd), .sync_wr(sync_wr), .sync_word(sync_word));

  always @(posedge clk) begin
    if (rx_rd) rx_rd_cnt <= rx_rd_cnt + 1;
    if (sync_wr) sync_wr_cnt <= sync_wr_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] code(input logic [2:0] op, input logic sel);
    return {4'h4, sel, op};
  endfunction

  function automatic logic exp_irq_n();
    return !(m_pend && m_ctrl[3]);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] dout, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; cmd_din = dout[i];
      wait_clk(6);
      got[i] = reply_dout;
      sclk = 1'b1;
      wait_clk(6);
    end
  endtask

  task automatic frame_start(); cs_n = 1'b0; wait_clk(4); endtask
  task automatic frame_end(); sclk = 1'b0; wait_clk(6); cs_n = 1'b1; wait_clk(8); endtask

  task automatic write2(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] g;
    frame_start(); xfer(c, g); xfer(d, g); frame_end();
  endtask

  task automatic read1(input logic [7:0] c, output logic [7:0] got);
    logic [7:0] g;
    frame_start(); xfer(c, g); xfer(8'h00, got); frame_end();
  endtask

  task automatic model_ctrl(input logic [7:0] v);
    if (v[0] != m_ctrl[0]) begin
      m_pend = 1'b0;
      m_stat = v[0] ? (m_stat & 6'b001100) : (m_stat & 6'b110011);
    end
    m_ctrl = v & 8'h3F;
  endtask

  task automatic pulse(input logic [5:0] mask);
    status_set = mask; wait_clk(1); status_set = 6'h00; wait_clk(3);
    m_stat |= mask;
    if (mask != 0) m_pend = 1'b1;
    if (mask[4]) m_ctrl[4] = 1'b0;
    if (mask[5]) m_ctrl[5] = 1'b0;
  endtask

  task automatic read_status(input string req);
    logic [7:0] got;
    read1(code(3'd1, addr_sel), got);
    chk(req, got, {2'b00, m_stat});
    m_stat &= 6'b001111; m_pend = 1'b0;
  endtask

  task automatic check_outs(input string req);
    chk({req, " ctrl"}, ctrl_word, m_ctrl);
    chk({req, " irq"}, irq_n, exp_irq_n());
    chk({req, " psave"}, powersave, wake & m_ctrl[2]);
  endtask

  initial begin
    logic [7:0] got;
    int cnt0;
    void'($urandom(32'd4242));
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    // Reset state
    chk("R7 reset oe", reply_oe, 0);
    chk("R9 reset irq", irq_n, 1);
    chk("R11 reset tx_valid", tx_valid, 0);
    check_outs("R3 reset");

    // R2/R3: control write, top bits forced to zero
    write2(code(3'd0, 1'b0), 8'hCE); model_ctrl(8'hCE);
    check_outs("R3 write CE");
    chk("R7 oe idle", reply_oe, 0);

    // R1: chip select lifted mid-byte
    frame_start(); xfer(code(3'd0, 1'b0), got);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; cmd_din = 1'b1; wait_clk(6); sclk = 1'b1; wait_clk(6);
    end
    frame_end();
    check_outs("R1 partial");

    // R4: strap moves map
    addr_sel = 1'b1;
    write2(code(3'd0, 1'b0), 8'h01);
    check_outs("R4 wrong map ignored");
    write2(code(3'd0, 1'b1), 8'h06); model_ctrl(8'h06);
    check_outs("R4 right map");
    // R5: broadcast reset on either map keeps status
    pulse(6'h04);
    write2(8'h01, 8'h00); m_ctrl = 8'h00;
    check_outs("R5 reset with strap 1");
    read_status("R5 status kept");
    addr_sel = 1'b0;

    // R6: sync word
    cnt0 = sync_wr_cnt;
    frame_start(); xfer(code(3'd4, 1'b0), got); xfer(8'hA5, got); xfer(8'h3C, got); frame_end();
    chk("R6 sync word", sync_word, 16'hA53C);
    chk("R6 sync pulse count", sync_wr_cnt - cnt0, 1);

    // R9/R14: detection event with interrupt enable and primes
    write2(code(3'd0, 1'b0), 8'h38); model_ctrl(8'h38);
    check_outs("R9 pre-event");
    pulse(6'h10);
    check_outs("R14 R9 after event");
    chk("R9 irq asserted", irq_n, 0);
    // R7/R8: status read and release
    read_status("R7 status value");
    check_outs("R8 after read");
    read_status("R8 sync flag cleared");

    // R10: mode change to transmit
    pulse(6'h3F);
    write2(code(3'd0, 1'b0), 8'h09); model_ctrl(8'h09);
    check_outs("R10 flip to tx");
    read_status("R10 flags after tx flip");
    pulse(6'h3F);
    write2(code(3'd0, 1'b0), 8'h08); model_ctrl(8'h08);
    check_outs("R10 flip to rx");
    read_status("R10 flags after rx flip");

    // R11: transmit byte with back-pressure
    pulse(6'h0C);
    write2(code(3'd3, 1'b0), 8'h77); m_stat &= 6'b110011;
    chk("R11 tx_valid", tx_valid, 1);
    chk("R11 tx_data", tx_data, 8'h77);
    wait_clk(20);
    chk("R11 held", tx_valid, 1);
    tx_ready = 1'b1; wait_clk(3); tx_ready = 1'b0;
    chk("R11 taken", tx_valid, 0);
    read_status("R11 tx flags cleared");

    // R12: receive byte read
    pulse(6'h03);
    rx_data = 8'h9C; cnt0 = rx_rd_cnt;
    read1(code(3'd2, 1'b0), got); m_stat &= 6'b111100;
    chk("R12 rx value", got, 8'h9C);
    chk("R12 rx_rd count", rx_rd_cnt - cnt0, 1);
    read_status("R12 rx flags cleared");

    // R13: powersave
    write2(code(3'd0, 1'b0), 8'h04); model_ctrl(8'h04);
    wake = 1'b1; wait_clk(2);
    chk("R13 psave on", powersave, 1);
    wake = 1'b0; wait_clk(2);
    chk("R13 psave off", powersave, 0);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      logic [7:0] v;
      op = int'($urandom % 7);
      v = 8'($urandom);
      wake = 1'($urandom);
      addr_sel = 1'($urandom);
      case (op)
        0: begin write2(code(3'd0, addr_sel), v); model_ctrl(v); end
        1: pulse(6'(v));
        2: read_status("R7 random status");
        3: begin
             rx_data = v; read1(code(3'd2, addr_sel), got); m_stat &= 6'b111100;
             chk("R12 random rx", got, v);
           end
        4: begin
             write2(code(3'd3, addr_sel), v); m_stat &= 6'b110011;
             chk("R11 random tx", tx_data, v);
             tx_ready = 1'b1; wait_clk(2); tx_ready = 1'b0;
           end
        5: write2(code(3'(v % 5), ~addr_sel), v);
        default: begin write2(8'h01, v); m_ctrl = 8'h00; end
      endcase
      wait_clk(2);
      check_outs("R4 R9 R13 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule